// File: doc/BRIEF.md
# Mode-Aware Capability Instruction Decoder

This block sits behind instruction fetch and classifies each 32-bit or 16-bit instruction word by two pieces of state. The first is a per-privilege capability-enable bit. The second is the mode flag of the current program-counter capability. From these two bits it picks one of three meanings for each opcode: the plain integer form, the capability form, or illegal.

For control transfers it also works out the tag of the next program-counter capability. A jump or trap return that would land in capability mode at a level where capabilities are disabled gets its tag cleared. The following fetch then takes an instruction access fault before address translation.

The state where the extension is disabled but the current mode flag is set is never given a decode mapping of its own. Whenever the block sees it, it reports a program-counter capability fault instead. All results are registered, one cycle after the valid strobe.

Top module: `cap_mode_decoder`

## Requirements
- R1: Outputs are registered. A word presented with `insn_valid_i` high appears on the outputs one clock later with `out_valid_o` high. A clock edge with `insn_valid_i` low drives all outputs to 0 on the next cycle. Reset also clears all outputs to 0.
- R2: With `cap_en_i`=1 and `pcc_mode_i`=0, the following hold:
  - A 32-bit word with major opcode 1100111 and bits[14:12]=000 gives op 1 (integer jump).
  - A 16-bit word with bits[1:0]=00 and bits[15:13]=001 gives op 3 (compressed double load).
  - A 32-bit word with major opcode 1011011 gives op 7 (capability operation) and is legal.
- R3: With `cap_en_i`=1 and `pcc_mode_i`=1, the following hold:
  - The register jump gives op 2 (capability jump).
  - The compressed double load slot gives op 4 (compressed capability load).
  - Opcode 1011011 still gives op 7 and is legal.
- R4: With `cap_en_i`=0 and `pcc_mode_i`=0, the following hold:
  - Opcode 1011011 raises `illegal_o` with op 0.
  - Integer forms decode as in R2 (op 1, op 3, op 5).
- R5: With `cap_en_i`=0 and `pcc_mode_i`=1, any valid word raises `pcc_fault_o`. In that case `illegal_o`=0, op=0 and `next_tag_o`=1. `pcc_fault_o` and `illegal_o` are never high together.
- R6: A trap return (word 0x30200073 or 0x10200073) gives op 8. Its `next_tag_o` is 0 when `tgt_flag_i`=1 and `dest_en_i`=0. Otherwise it equals `tgt_tag_i`.
- R7: A capability jump (op 2) with `tgt_flag_i`=1 and `dest_en_i`=0 gives `next_tag_o`=0. Otherwise it equals `tgt_tag_i`. An integer jump (op 1) always passes `tgt_tag_i` through.
- R8: A 16-bit word with bits[1:0]=10, bits[15:13]=100, bit 12=0 and bits[6:2]≠0 gives op 5 (integer move) outside capability mode. In capability mode it gives op 6 (capability move).
- R9: A word whose low 16 bits are all zero is reported illegal with op 0 in every mode that is not a fault (R5).
- R10: Any other legal word gives op 9 with `next_tag_o`=1. Every non-transfer legal op also gives `next_tag_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| insn_valid_i | input | 1 | Instruction word present this cycle |
| insn_i | input | 32 | Fetched word; a 16-bit instruction sits in bits[15:0] |
| cap_en_i | input | 1 | Capability enable for the current privilege level |
| pcc_mode_i | input | 1 | Mode flag of the current program-counter capability |
| dest_en_i | input | 1 | Capability enable of the level a transfer lands in |
| tgt_flag_i | input | 1 | Mode flag of the transfer target capability |
| tgt_tag_i | input | 1 | Tag of the transfer target capability |
| out_valid_o | output | 1 | Registered result valid |
| op_o | output | 4 | Decoded operation code (see R2–R10) |
| illegal_o | output | 1 | Illegal instruction |
| next_tag_o | output | 1 | Tag of the next program-counter capability |
| pcc_fault_o | output | 1 | Program-counter capability fault (instruction access, pre-translation) |

## Verification
The bench builds the block with its default parameters: the capability opcode at 1011011 and the compressed decoder present. This makes all four combinations of enable and mode flag reachable, for both instruction widths. Random draws of the two state bits, the destination enable and the target flag and tag land the cleared-tag returns and jumps, the fault state and the zero halfword alongside the ordinary mappings.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_JALR  = 4'd1,
        OP_CJALR = 4'd2,
        OP_CFLD  = 4'd3,
        OP_CCLC  = 4'd4,
        OP_MV    = 4'd5,
        OP_CMOVE = 4'd6,
        OP_CAPOP = 4'd7,
        OP_XRET  = 4'd8,
        OP_OTHER = 4'd9
    } op_e;

    typedef struct packed {
        op_e  op;
        logic ill;
    } cls_t;

    typedef struct packed {
        logic vld;
        op_e  op;
        logic ill;
        logic tag;
        logic flt;
    } dec_st_t;

    localparam logic [31:0] XRET_M = 32'h3020_0073;
    localparam logic [31:0] XRET_S = 32'h1020_0073;
    localparam logic [6:0]  JALR_OPC = 7'b1100111;
endpackage

// File: rtl/cmd_wide_cls.sv
module cmd_wide_cls
    import cmd_pkg::*;
#(
    parameter int          ILEN    = 32,
    parameter logic [6:0]  CAP_OPC = 7'b1011011
) (
    input  logic [ILEN-1:0] insn_i,
    input  logic            cap_en_i,
    input  logic            cap_mode_i,
    output cls_t            cls_o
);
    logic [6:0] opc;
    logic [2:0] f3;

    always_comb begin
        opc       = insn_i[6:0];
        f3        = insn_i[14:12];
        cls_o.op  = OP_OTHER;
        cls_o.ill = 1'b0;
        if (insn_i[31:0] == XRET_M || insn_i[31:0] == XRET_S) begin
            cls_o.op = OP_XRET;
        end else if (opc == JALR_OPC && f3 == 3'b000) begin
            cls_o.op = cap_mode_i ? OP_CJALR : OP_JALR;
        end else if (opc == CAP_OPC) begin
            if (cap_en_i) begin
                cls_o.op = OP_CAPOP;
            end else begin
                cls_o.op  = OP_NONE;
                cls_o.ill = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmd_rvc_cls.sv
module cmd_rvc_cls
    import cmd_pkg::*;
#(
    parameter int HLEN = 16
) (
    input  logic [HLEN-1:0] half_i,
    input  logic            cap_mode_i,
    output cls_t            cls_o
);
    logic [1:0] quad;
    logic [2:0] f3;

    always_comb begin
        quad      = half_i[1:0];
        f3        = half_i[15:13];
        cls_o.op  = OP_OTHER;
        cls_o.ill = 1'b0;
        if (half_i == '0) begin
            cls_o.op  = OP_NONE;
            cls_o.ill = 1'b1;
        end else if (quad == 2'b00 && f3 == 3'b001) begin
            cls_o.op = cap_mode_i ? OP_CCLC : OP_CFLD;
        end else if (quad == 2'b10 && f3 == 3'b100 && !half_i[12] && half_i[6:2] != 5'd0) begin
            cls_o.op = cap_mode_i ? OP_CMOVE : OP_MV;
        end
    end
endmodule

// File: rtl/cmd_tag_guard.sv
module cmd_tag_guard
    import cmd_pkg::*;
(
    input  op_e  op_i,
    input  logic dest_en_i,
    input  logic tgt_flag_i,
    input  logic tgt_tag_i,
    output logic next_tag_o
);
    logic checked_xfer;
    logic any_xfer;
    logic clr;

    always_comb begin
        checked_xfer = (op_i == OP_CJALR) || (op_i == OP_XRET);
        any_xfer     = checked_xfer || (op_i == OP_JALR);
        clr          = checked_xfer && tgt_flag_i && !dest_en_i;
        next_tag_o   = any_xfer ? (tgt_tag_i && !clr) : 1'b1;
    end
endmodule

// File: rtl/cap_mode_decoder.sv
module cap_mode_decoder
    import cmd_pkg::*;
#(
    parameter int         ILEN    = 32,
    parameter logic [6:0] CAP_OPC = 7'b1011011,
    parameter bit         HAS_RVC = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            insn_valid_i,
    input  logic [ILEN-1:0] insn_i,
    input  logic            cap_en_i,
    input  logic            pcc_mode_i,
    input  logic            dest_en_i,
    input  logic            tgt_flag_i,
    input  logic            tgt_tag_i,
    output logic            out_valid_o,
    output logic [3:0]      op_o,
    output logic            illegal_o,
    output logic            next_tag_o,
    output logic            pcc_fault_o
);
    localparam int HLEN = ILEN / 2;

    dec_st_t st_d, st_q;
    cls_t    wide_cls, half_cls, sel_cls;
    logic    cap_mode, bad_mode, is_wide, guard_tag;

    assign cap_mode = cap_en_i && pcc_mode_i;
    assign bad_mode = !cap_en_i && pcc_mode_i;
    assign is_wide  = (insn_i[1:0] == 2'b11);

    cmd_wide_cls #(.ILEN(ILEN), .CAP_OPC(CAP_OPC)) u_wide (
        .insn_i     (insn_i),
        .cap_en_i   (cap_en_i),
        .cap_mode_i (cap_mode),
        .cls_o      (wide_cls)
    );

    generate
        if (HAS_RVC) begin : g_rvc
            cmd_rvc_cls #(.HLEN(HLEN)) u_half (
                .half_i     (insn_i[HLEN-1:0]),
                .cap_mode_i (cap_mode),
                .cls_o      (half_cls)
            );
        end else begin : g_no_rvc
            assign half_cls = '{op: OP_NONE, ill: 1'b1};
        end
    endgenerate

    assign sel_cls = is_wide ? wide_cls : half_cls;

    cmd_tag_guard u_guard (
        .op_i       (sel_cls.op),
        .dest_en_i  (dest_en_i),
        .tgt_flag_i (tgt_flag_i),
        .tgt_tag_i  (tgt_tag_i),
        .next_tag_o (guard_tag)
    );

    always_comb begin
        st_d = '0;
        if (insn_valid_i) begin
            st_d.vld = 1'b1;
            if (bad_mode) begin
                st_d.op  = OP_NONE;
                st_d.flt = 1'b1;
                st_d.tag = 1'b1;
            end else if (sel_cls.ill) begin
                st_d.op  = OP_NONE;
                st_d.ill = 1'b1;
                st_d.tag = 1'b1;
            end else begin
                st_d.op  = sel_cls.op;
                st_d.tag = guard_tag;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.vld;
    assign op_o        = st_q.op;
    assign illegal_o   = st_q.ill;
    assign next_tag_o  = st_q.tag;
    assign pcc_fault_o = st_q.flt;
endmodule

// File: rtl/cmd_checker.sv
module cmd_checker #(
    parameter int         ILEN    = 32,
    parameter logic [6:0] CAP_OPC = 7'b1011011
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            insn_valid_i,
    input logic [ILEN-1:0] insn_i,
    input logic            cap_en_i,
    input logic            pcc_mode_i,
    input logic            dest_en_i,
    input logic            tgt_flag_i,
    input logic            out_valid_o,
    input logic [3:0]      op_o,
    input logic            illegal_o,
    input logic            next_tag_o,
    input logic            pcc_fault_o
);
    p_valid_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        insn_valid_i |=> out_valid_o);

    p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !insn_valid_i |=> (!out_valid_o && !illegal_o && !pcc_fault_o));

    p_fault_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pcc_fault_o |-> !illegal_o);

    p_bad_mode_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_valid_i && !cap_en_i && pcc_mode_i) |=> pcc_fault_o);

    p_capop_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_valid_i && !cap_en_i && !pcc_mode_i && insn_i[6:0] == CAP_OPC) |=> illegal_o);

    p_zero_half_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_valid_i && insn_i[15:0] == 16'd0) |=> (illegal_o || pcc_fault_o));

    p_cjalr_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_valid_i && cap_en_i && pcc_mode_i && insn_i[6:0] == 7'b1100111
         && insn_i[14:12] == 3'b000 && tgt_flag_i && !dest_en_i) |=> !next_tag_o);
endmodule

bind cap_mode_decoder cmd_checker #(.ILEN(ILEN), .CAP_OPC(CAP_OPC)) u_cmd_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .insn_valid_i (insn_valid_i),
    .insn_i       (insn_i),
    .cap_en_i     (cap_en_i),
    .pcc_mode_i   (pcc_mode_i),
    .dest_en_i    (dest_en_i),
    .tgt_flag_i   (tgt_flag_i),
    .out_valid_o  (out_valid_o),
    .op_o         (op_o),
    .illegal_o    (illegal_o),
    .next_tag_o   (next_tag_o),
    .pcc_fault_o  (pcc_fault_o)
);

// File: tb/tb_cap_mode_decoder.sv
module tb_cap_mode_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [31:0] insn = '0;
    logic        en = 1'b0, mode = 1'b0, den = 1'b0, tflag = 1'b0, ttag = 1'b0;
    logic        ovld, ill, ntag, flt;
    logic [3:0]  op;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    cap_mode_decoder dut (
        .clk_i(clk), .rst_ni(rst_n), .insn_valid_i(vld), .insn_i(insn),
        .cap_en_i(en), .pcc_mode_i(mode), .dest_en_i(den),
        .tgt_flag_i(tflag), .tgt_tag_i(ttag),
        .out_valid_o(ovld), .op_o(op), .illegal_o(ill),
        .next_tag_o(ntag), .pcc_fault_o(flt)
    );

    // expected {op, ill, flt, tag} from the requirements
    function automatic logic [6:0] model(logic [31:0] w, logic e, logic m,
                                         logic de, logic tf, logic tt);
        logic [3:0] o;
        logic       il, cm;
        logic       tg;
        cm = e && m;
        il = 1'b0;
        o  = 4'd9;
        if (!e && m) return {4'd0, 1'b0, 1'b1, 1'b1};               // R5
        if (w[1:0] == 2'b11) begin
            if (w == 32'h3020_0073 || w == 32'h1020_0073) o = 4'd8;  // R6
            else if (w[6:0] == 7'b1100111 && w[14:12] == 3'b000) o = cm ? 4'd2 : 4'd1;
            else if (w[6:0] == 7'b1011011) begin
                if (e) o = 4'd7; else begin o = 4'd0; il = 1'b1; end // R4
            end
        end else begin
            if (w[15:0] == 16'd0) begin o = 4'd0; il = 1'b1; end     // R9
            else if (w[1:0] == 2'b00 && w[15:13] == 3'b001) o = cm ? 4'd4 : 4'd3;
            else if (w[1:0] == 2'b10 && w[15:13] == 3'b100 && !w[12] && w[6:2] != 0)
                o = cm ? 4'd6 : 4'd5;                                // R8
        end
        if (il) tg = 1'b1;
        else if (o == 4'd1) tg = tt;
        else if (o == 4'd2 || o == 4'd8) tg = tt && !(tf && !de);   // R6 R7
        else tg = 1'b1;                                              // R10
        return {o, il, 1'b0, tg};
    endfunction

    task automatic check(string req, logic [6:0] act, logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s insn=%08h en=%0b mode=%0b act={op %0d ill %0b flt %0b tag %0b} exp={op %0d ill %0b flt %0b tag %0b}",
                     req, insn, en, mode, act[6:3], act[2], act[1], act[0],
                     exp[6:3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic apply(string req, logic [31:0] w, logic e, logic m,
                         logic de, logic tf, logic tt);
        logic [6:0] exp;
        insn = w; en = e; mode = m; den = de; tflag = tf; ttag = tt; vld = 1'b1;
        exp = model(w, e, m, de, tf, tt);
        @(negedge clk);
        check(req, {op, ill, flt, ntag}, exp);
        checks++;
        if (ovld !== 1'b1) begin
            errors++;
            $display("FAIL R1 out_valid act=%0b exp=1", ovld);
        end
    endtask

    function automatic logic [31:0] rand_word(int kind);
        logic [31:0] r;
        r = $urandom;
        case (kind)
            0: return {r[31:15], 3'b000, r[11:7], 7'b1100111};
            1: return {r[31:7], 7'b1011011};
            2: return r[0] ? 32'h3020_0073 : 32'h1020_0073;
            3: return {r[31:16], 3'b001, r[12:2], 2'b00};
            4: return {r[31:16], 4'b1000, r[11:7], (r[6:2] == 0 ? 5'd3 : r[6:2]), 2'b10};
            5: return {r[31:16], 16'h0000};
            default: return {r[31:15], 3'b000, r[11:7], 7'b0110011};
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;  // R1 reset state
        if ({ovld, op, ill, ntag, flt} !== 8'd0) begin
            errors++;
            $display("FAIL R1 reset act=%b exp=0", {ovld, op, ill, ntag, flt});
        end
        rst_n = 1'b1;
        @(negedge clk);

        apply("R2", 32'h0000_8067, 1, 0, 1, 1, 1);
        apply("R2", 32'h0000_2000 | 32'h0000_0000, 1, 0, 1, 0, 1);
        apply("R2", 32'h1234_505B, 1, 0, 1, 0, 1);
        apply("R3", 32'h0000_8067, 1, 1, 1, 1, 1);
        apply("R3", 32'h0000_2004, 1, 1, 1, 0, 1);
        apply("R3", 32'h0000_005B, 1, 1, 1, 0, 1);
        apply("R4", 32'h0000_005B, 0, 0, 0, 0, 1);
        apply("R4", 32'h0000_8067, 0, 0, 0, 1, 1);
        apply("R5", 32'h0000_8067, 0, 1, 0, 1, 1);
        apply("R5", 32'h0000_0000, 0, 1, 0, 0, 0);
        apply("R6", 32'h3020_0073, 1, 0, 0, 1, 1);
        apply("R6", 32'h1020_0073, 1, 1, 1, 1, 1);
        apply("R6", 32'h3020_0073, 1, 0, 0, 0, 0);
        apply("R7", 32'h0000_8067, 1, 1, 0, 1, 1);
        apply("R7", 32'h0000_8067, 1, 0, 0, 1, 1);
        apply("R8", 32'h0000_808A, 1, 0, 1, 0, 1);
        apply("R8", 32'h0000_808A, 1, 1, 1, 0, 1);
        apply("R9", 32'hFFFF_0000, 1, 1, 1, 0, 1);
        apply("R9", 32'h0000_0000, 0, 0, 1, 0, 1);
        apply("R10", 32'h00B5_0533, 1, 0, 0, 1, 0);

        vld = 1'b0;
        @(negedge clk);
        checks++;  // R1 idle clears outputs
        if ({ovld, op, ill, ntag, flt} !== 8'd0) begin
            errors++;
            $display("FAIL R1 idle act=%b exp=0", {ovld, op, ill, ntag, flt});
        end

        void'($urandom(32'd5150));
        for (int i = 0; i < 400; i++) begin
            int          k;
            logic [3:0]  b;
            logic [31:0] w;
            string       tag;
            k = $urandom_range(0, 6);
            b = 4'($urandom);
            w = rand_word(k);
            case (k)
                0: tag = "R7"; 1: tag = "R4"; 2: tag = "R6"; 3: tag = "R3";
                4: tag = "R8"; 5: tag = "R9"; default: tag = "R10";
            endcase
            if (!b[0] && b[1]) tag = "R5";
            apply(tag, w, b[0], b[1], b[2], b[3], 1'($urandom));
        end

        vld = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule